// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Controller

This block gathers the interrupt sources of a two-channel serial unit into one 8-bit read-only status register and drives a single active-low interrupt request. Seven of the status bits are registered copies of level inputs that arrive from the transmitters, the receivers and the counter/timer. These inputs are the transmitter-ready, receiver-ready and break-change flags of each channel, plus one timer-ready flag. The eighth bit reports a change of state on three general-purpose input pins.

Each pin passes through a two-flop synchronizer and an edge detector. Any transition sets a per-pin change latch. A per-pin enable bit decides whether that latch reaches the status register's top bit. A read/write mask register picks which status bits may pull the request low. Status reads always show the unmasked truth. Reading the change register clears the pin latches.

Register map on the 2-bit address: 0 is status (read only), 1 is mask (read/write), 2 is the change register (read only, clear on read), and 3 is the pin enable register (read/write, bits 2:0).

Top module: `serial_irq_ctrl`

## Requirements
- R1: Status bit positions are: bit 0 channel A transmitter ready, bit 1 channel A receiver ready, bit 2 channel A break change, bit 3 counter/timer ready, bit 4 channel B transmitter ready, bit 5 channel B receiver ready, bit 6 channel B break change, bit 7 change of state. Bits 6:0 follow their inputs one clock later.
- R2: `irq_n_o` is low exactly when some status bit and its mask bit are both 1. It is registered, so it changes one clock after the status or mask change.
- R3: A read of address 0 returns the true status whatever the mask holds.
- R4: Writes to address 0 have no effect on the status.
- R5: After reset, status, mask, enables and change latches are 0 and `irq_n_o` is high.
- R6: A transition on pin k sets change latch k three clocks after it reaches the pin, whatever its enable. A read of address 2 returns the latches in bits 2:0 and the synchronized pin levels in bits 6:4.
- R7: Status bit 7 is 1 exactly when some change latch is set and its enable bit (address 3, bit k for pin k) is 1. A disabled pin's transition leaves bit 7 at 0.
- R8: Reading address 2 clears all change latches, and with them bit 7. A transition detected in the same clock wins, and its latch stays set.
- R9: The mask at address 1 reads back all 8 bits written. The enable register at address 3 reads back bits 2:0, and its other bits read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_i | input | 1 | Register access strobe, one clock per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the addressed register (combinational) |
| pins_i | input | NUM_PINS | Asynchronous input pins watched for change of state |
| a_txrdy_i | input | 1 | Channel A transmitter ready |
| a_rxrdy_i | input | 1 | Channel A receiver ready |
| a_brkchg_i | input | 1 | Channel A break change |
| ctr_rdy_i | input | 1 | Counter/timer ready |
| b_txrdy_i | input | 1 | Channel B transmitter ready |
| b_rxrdy_i | input | 1 | Channel B receiver ready |
| b_brkchg_i | input | 1 | Channel B break change |
| irq_n_o | output | 1 | Interrupt request, active low, registered |

## Verification
The assertions take for granted that a read of address 2 lasts a single clock, so one strobe clears the latches once. They also assume the source flags are already synchronous to `clk`, which lets status bits 6:0 equal the flags seen one clock earlier. The stimulus drives every input just after a falling edge and pulses `cs_i` for exactly one clock per access. It changes pins only when the bench's model can account for the three-clock latch delay, with one deliberate exception: a read lands in the detection clock to show that the set wins.

// File: rtl/sic_pkg.sv
package sic_pkg;
    localparam int STAT_W  = 8;
    localparam int SRC_W   = 7;
    localparam int COS_BIT = 7;
    localparam int LVL_LSB = 4;

    typedef enum logic [1:0] {
        REG_STATUS = 2'd0,
        REG_MASK   = 2'd1,
        REG_CHANGE = 2'd2,
        REG_ENABLE = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/sic_cos_detect.sv
module sic_cos_detect #(
    parameter int NUM_PINS    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pins_i,
    input  logic                clear_i,
    input  logic [NUM_PINS-1:0] enable_i,
    output logic [NUM_PINS-1:0] level_o,
    output logic [NUM_PINS-1:0] latch_o,
    output logic [NUM_PINS-1:0] event_o,
    output logic                cos_o
);
    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0][NUM_PINS-1:0] sync;
        logic [NUM_PINS-1:0]                  prev;
        logic [NUM_PINS-1:0]                  latch;
    } cos_state_t;

    cos_state_t st_d, st_q;
    logic [NUM_PINS-1:0] chg;
    logic [NUM_PINS-1:0] gated;

    always_comb begin
        st_d         = st_q;
        st_d.sync[0] = pins_i;
        for (int s = 1; s < SYNC_STAGES; s++) begin
            st_d.sync[s] = st_q.sync[s-1];
        end
        st_d.prev  = st_q.sync[LAST];
        chg        = st_q.sync[LAST] ^ st_q.prev;
        st_d.latch = (st_q.latch & ~{NUM_PINS{clear_i}}) | chg;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar k = 0; k < NUM_PINS; k++) begin : g_gate
        assign gated[k] = st_q.latch[k] & enable_i[k];
    end

    assign level_o = st_q.sync[LAST];
    assign latch_o = st_q.latch;
    assign event_o = chg;
    assign cos_o   = |gated;
endmodule

// File: rtl/sic_irq_gen.sv
module sic_irq_gen #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] status_i,
    input  logic [WIDTH-1:0] mask_i,
    output logic             irq_n_o
);
    typedef struct packed {
        logic irq_n;
    } irq_state_t;

    irq_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.irq_n = ~|(status_i & mask_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{irq_n: 1'b1};
        else        st_q <= st_d;
    end

    assign irq_n_o = st_q.irq_n;
endmodule

// File: rtl/serial_irq_ctrl.sv
module serial_irq_ctrl
    import sic_pkg::*;
#(
    parameter int NUM_PINS    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cs_i,
    input  logic                we_i,
    input  logic [1:0]          addr_i,
    input  logic [STAT_W-1:0]   wdata_i,
    output logic [STAT_W-1:0]   rdata_o,
    input  logic [NUM_PINS-1:0] pins_i,
    input  logic                a_txrdy_i,
    input  logic                a_rxrdy_i,
    input  logic                a_brkchg_i,
    input  logic                ctr_rdy_i,
    input  logic                b_txrdy_i,
    input  logic                b_rxrdy_i,
    input  logic                b_brkchg_i,
    output logic                irq_n_o
);
    typedef struct packed {
        logic [STAT_W-1:0]   mask;
        logic [NUM_PINS-1:0] enable;
        logic [SRC_W-1:0]    src;
    } reg_state_t;

    reg_state_t st_d, st_q;

    logic [SRC_W-1:0]    src_in;
    logic [STAT_W-1:0]   status_vec;
    logic [NUM_PINS-1:0] pin_level;
    logic [NUM_PINS-1:0] chg_latch;
    logic [NUM_PINS-1:0] chg_event;
    logic                cos;
    logic                wr_en;
    logic                rd_change;
    logic [STAT_W-1:0]   mask_q;
    logic [NUM_PINS-1:0] enable_q;

    assign src_in = {b_brkchg_i, b_rxrdy_i, b_txrdy_i, ctr_rdy_i,
                     a_brkchg_i, a_rxrdy_i, a_txrdy_i};

    assign wr_en     = cs_i & we_i;
    assign rd_change = cs_i & ~we_i & (reg_addr_e'(addr_i) == REG_CHANGE);

    always_comb begin
        st_d     = st_q;
        st_d.src = src_in;
        if (wr_en) begin
            case (reg_addr_e'(addr_i))
                REG_MASK:   st_d.mask   = wdata_i;
                REG_ENABLE: st_d.enable = wdata_i[NUM_PINS-1:0];
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    sic_cos_detect #(
        .NUM_PINS   (NUM_PINS),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_cos (
        .clk     (clk),
        .rst_n   (rst_n),
        .pins_i  (pins_i),
        .clear_i (rd_change),
        .enable_i(st_q.enable),
        .level_o (pin_level),
        .latch_o (chg_latch),
        .event_o (chg_event),
        .cos_o   (cos)
    );

    assign status_vec = {cos, st_q.src};
    assign mask_q     = st_q.mask;
    assign enable_q   = st_q.enable;

    sic_irq_gen #(.WIDTH(STAT_W)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .status_i(status_vec),
        .mask_i  (st_q.mask),
        .irq_n_o (irq_n_o)
    );

    always_comb begin
        rdata_o = '0;
        case (reg_addr_e'(addr_i))
            REG_STATUS: rdata_o = status_vec;
            REG_MASK:   rdata_o = st_q.mask;
            REG_CHANGE: begin
                rdata_o[NUM_PINS-1:0]         = chg_latch;
                rdata_o[LVL_LSB +: NUM_PINS]  = pin_level;
            end
            REG_ENABLE: rdata_o[NUM_PINS-1:0] = st_q.enable;
            default:    rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/sic_checker.sv
module sic_checker #(
    parameter int NUM_PINS = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cs_i,
    input logic                we_i,
    input logic [1:0]          addr_i,
    input logic [7:0]          rdata_o,
    input logic [6:0]          src_in,
    input logic [7:0]          status_vec,
    input logic [7:0]          mask_q,
    input logic [NUM_PINS-1:0] enable_q,
    input logic [NUM_PINS-1:0] chg_latch,
    input logic [NUM_PINS-1:0] chg_event,
    input logic                rd_change,
    input logic                irq_n_o
);
    AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq_n_o == ~|($past(status_vec & mask_q)))); // R2

    AST_STATUS_TRUE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && cs_i && !we_i && addr_i == 2'd0) |-> (rdata_o[6:0] == $past(src_in))); // R3

    AST_COS_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_i && !we_i && addr_i == 2'd0 && rdata_o[7]) |-> (enable_q != '0)); // R7

    AST_CLEAR_KEEPS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rd_change)) |-> (chg_latch == $past(chg_event))); // R8

    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (irq_n_o && chg_latch == '0 && mask_q == '0)); // R5
endmodule

bind serial_irq_ctrl sic_checker #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_i      (cs_i),
    .we_i      (we_i),
    .addr_i    (addr_i),
    .rdata_o   (rdata_o),
    .src_in    (src_in),
    .status_vec(status_vec),
    .mask_q    (mask_q),
    .enable_q  (enable_q),
    .chg_latch (chg_latch),
    .chg_event (chg_event),
    .rd_change (rd_change),
    .irq_n_o   (irq_n_o)
);

// File: tb/test_serial_irq_ctrl.sv
module test_serial_irq_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       cs, we;
    logic [1:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic [2:0] pins;
    logic [6:0] src;
    logic       irq_n;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    logic [7:0] mask_m;
    logic [2:0] en_m, latch_m;

    always #4 clk = ~clk;

    serial_irq_ctrl i_serial_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .we_i(we), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .pins_i(pins),
        .a_txrdy_i(src[0]), .a_rxrdy_i(src[1]), .a_brkchg_i(src[2]),
        .ctr_rdy_i(src[3]), .b_txrdy_i(src[4]), .b_rxrdy_i(src[5]),
        .b_brkchg_i(src[6]), .irq_n_o(irq_n)
    );

    function automatic logic [7:0] exp_status(logic [6:0] s, logic [2:0] l, logic [2:0] e);
        return {|(l & e), s};
    endfunction

    function automatic logic exp_irq_n(logic [7:0] st, logic [7:0] m);
        return ~|(st & m);
    endfunction

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [1:0] a, logic [7:0] d);
        cs = 1'b1; we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; we = 1'b0;
    endtask

    task automatic bus_read(logic [1:0] a, output logic [7:0] d);
        cs = 1'b1; we = 1'b0; addr = a;
        #1 d = rdata;
        @(negedge clk);
        cs = 1'b0;
    endtask

    task automatic wait_cycles(int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual 0x00 expected 0x01");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic [7:0] st;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; cs = 1'b0; we = 1'b0; addr = '0; wdata = '0;
        pins = '0; src = '0;
        mask_m = '0; en_m = '0; latch_m = '0;
        wait_cycles(3);
        rst_n = 1'b1;

        // R5: reset state
        bus_read(2'd0, rd); check("R5 status", rd, 8'h00);
        bus_read(2'd1, rd); check("R5 mask", rd, 8'h00);
        bus_read(2'd3, rd); check("R5 enable", rd, 8'h00);
        bus_read(2'd2, rd); check("R5 change", rd, 8'h00);
        check("R5 irq_n", {7'd0, irq_n}, 8'h01);

        // R4: status is read only
        bus_write(2'd0, 8'hFF);
        bus_read(2'd0, rd); check("R4 write ignored", rd, 8'h00);

        // R9: mask and enable read back
        bus_write(2'd1, 8'hA5);
        bus_read(2'd1, rd); check("R9 mask", rd, 8'hA5);
        bus_write(2'd3, 8'hFF);
        bus_read(2'd3, rd); check("R9 enable", rd, 8'h07);
        bus_write(2'd3, 8'h00);

        // R1: channel B break change lands on bit 6 one clock later
        src = 7'h40;
        @(negedge clk);
        bus_read(2'd0, rd); check("R1 bit6", rd, 8'h40);
        check("R2 masked off", {7'd0, irq_n}, 8'h01);

        // R2: one-clock registered request
        bus_write(2'd1, 8'h01);
        src = 7'h41;
        @(negedge clk);
        check("R2 not yet", {7'd0, irq_n}, 8'h01);
        @(negedge clk);
        check("R2 asserted", {7'd0, irq_n}, 8'h00);

        // R3: mask cleared, status still true
        bus_write(2'd1, 8'h00);
        @(negedge clk);
        bus_read(2'd0, rd); check("R3 unmasked read", rd, 8'h41);
        check("R3 irq released", {7'd0, irq_n}, 8'h01);

        // R6/R7: disabled pin change
        src = 7'h00;
        pins = 3'b010;
        wait_cycles(4);
        bus_read(2'd0, rd); check("R7 disabled", rd, 8'h00);
        bus_write(2'd3, 8'h02);
        bus_read(2'd0, rd); check("R7 enabled", rd, 8'h80);
        bus_write(2'd1, 8'h80);
        @(negedge clk);
        check("R2 cos irq", {7'd0, irq_n}, 8'h00);
        bus_read(2'd2, rd); check("R6 latch and level", rd, 8'h22);
        bus_read(2'd0, rd); check("R8 cleared bit7", rd, 8'h00);
        bus_read(2'd2, rd); check("R8 latches clear", rd, 8'h20);

        // R6: exact three-clock latch delay
        pins = 3'b000;
        wait_cycles(2);
        bus_read(2'd2, rd); check("R6 not yet", rd, 8'h00);
        bus_read(2'd2, rd); check("R6 set after 3", rd, 8'h02);

        // R8: set wins over clear in the detection clock
        pins = 3'b001;
        wait_cycles(2);
        bus_read(2'd2, rd); check("R8 read in detect clock", rd, 8'h10);
        bus_read(2'd2, rd); check("R8 set wins", rd, 8'h11);
        bus_read(2'd2, rd); check("R8 cleared after", rd, 8'h10);

        // random phase
        mask_m = 8'h80; en_m = 3'b010; latch_m = '0;
        for (int it = 0; it < 300; it++) begin
            logic [2:0] tog;
            mask_m = 8'($urandom);
            en_m   = 3'($urandom);
            bus_write(2'd1, mask_m);
            bus_write(2'd3, {5'd0, en_m});
            src = 7'($urandom);
            tog = ($urandom % 3 == 0) ? 3'($urandom) : 3'b000;
            pins = pins ^ tog;
            latch_m = latch_m | tog;
            wait_cycles(4);
            st = exp_status(src, latch_m, en_m);
            bus_read(2'd0, rd); check("R3 random status", rd, st);
            check("R2 random irq", {7'd0, irq_n}, {7'd0, exp_irq_n(st, mask_m)});
            if ($urandom % 4 == 0) begin
                bus_read(2'd2, rd);
                check("R6 random change", rd, {1'b0, pins, 1'b0, latch_m});
                latch_m = '0;
            end
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule